// File: doc/BRIEF.md
# Sequential Next-Block Prefetch Generator with Request Merging

The block sits beside a cache controller and watches demand block accesses. For each accepted demand to block address B, it walks the following blocks B+1 up to B+N, where N is the current prefetch depth. It looks up each candidate in a small table of blocks that already have a request outstanding toward memory. A candidate that is already outstanding is merged and not issued again. A candidate that is not outstanding is presented on a valid/ready request port and, once accepted, is entered into the table. Completion notifications from memory remove blocks from the table.

The demand side is handled in the same way. A demand to a block that is already outstanding is merged into the existing request. A demand to any other block allocates a table entry and counts as new memory traffic. Two running counters give the number of demand accesses and the number of block requests actually sent to memory. Their ratio is the bandwidth cost of the prefetcher on a given access stream. The depth N is held in a register that can be rewritten at run time.

Top module: `nextn_prefetcher`

## Requirements
- R1: After reset, pf_valid_o is 0, dem_ready_o is 1, both counters read 0, the table holds no blocks and the depth register holds DEPTH_RST (2 by default).
- R2: A demand is accepted in a cycle where dem_valid_i and dem_ready_o are both 1. After an accepted demand to block B with depth N, the candidates B+1 to B+N are evaluated one per cycle in ascending order, starting the cycle after acceptance. dem_ready_o stays 0 for exactly N cycles, unless the request port stalls.
- R3: A candidate whose block is already in the table is merged. It is not presented on the request port, it does not change the total counter, and it takes one cycle.
- R4: An accepted demand to a block already in the table increments only the demand counter. An accepted demand to any other block increments both counters and, if the table has a free entry, is entered into the table.
- R5: While pf_valid_o is 1 and pf_ready_i is 0, pf_valid_o and pf_addr_o hold their values. A request is issued when pf_valid_o and pf_ready_i are both 1. An issued request enters the table and increments the total counter by one.
- R6: When all ENTRIES table entries are in use, a new candidate is dropped without being presented or counted. A demand that misses the table still counts toward the total but is not tracked.
- R7: A cycle with cmp_valid_i set removes the block cmp_addr_i from the table. A later candidate or demand to that block then counts as new traffic. Lookups in the same cycle still see the block.
- R8: cfg_we_i loads cfg_depth_i into the depth register. Values above N_MAX are stored as N_MAX. A depth of 0 produces no candidates.
- R9: Both counters wrap modulo 2^CNT_W and change by at most one per cycle.
- R10: With depth 2 and the demand stream 0,1,2,7,8,9, where the five blocks of each group are completed after it, the totals are 6 demands and 10 requests. This is a request-to-demand ratio of 5/3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the depth register |
| cfg_depth_i | input | NW | New prefetch depth |
| dem_valid_i | input | 1 | Demand access present |
| dem_addr_i | input | ADDR_W | Demand block address |
| dem_ready_o | output | 1 | Demand can be accepted (no burst in progress) |
| cmp_valid_i | input | 1 | Completion present |
| cmp_addr_i | input | ADDR_W | Completed block address |
| pf_valid_o | output | 1 | Prefetch request valid |
| pf_addr_o | output | ADDR_W | Prefetch block address |
| pf_ready_i | input | 1 | Prefetch request accepted |
| dem_cnt_o | output | CNT_W | Accepted demand count |
| tot_cnt_o | output | CNT_W | Block requests sent to memory |

## Verification
The assertions check several properties on every cycle. The table never holds the same block twice and is never written while full. A presented prefetch is never for an outstanding block. A stalled request holds steady. Every issued request moves the total counter, and neither counter jumps. The ordering and skipping of candidates, merging against earlier requests, dropping when the table is full, depth clamping and the 5/3 traffic ratio depend on the history of addresses. Only the bench scenarios can show them, by comparing issued addresses, burst lengths and counter deltas against values worked out by hand.

// File: rtl/nnp_pkg.sv
package nnp_pkg;
  typedef enum logic {
    BST_IDLE = 1'b0,
    BST_RUN  = 1'b1
  } burst_st_e;
endpackage

// File: rtl/nnp_depth_reg.sv
module nnp_depth_reg #(
  parameter int N_MAX     = 8,
  parameter int NW        = 4,
  parameter int DEPTH_RST = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [NW-1:0] val_i,
  output logic [NW-1:0] depth_o
);
  localparam logic [NW-1:0] MaxVal = NW'(N_MAX);
  localparam logic [NW-1:0] RstVal = (DEPTH_RST > N_MAX) ? NW'(N_MAX) : NW'(DEPTH_RST);

  logic [NW-1:0] depth_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    depth_q <= RstVal;
    else if (we_i)  depth_q <= (val_i > MaxVal) ? MaxVal : val_i;
  end

  assign depth_o = depth_q;

  assert_depth_clamped_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_o <= MaxVal);
endmodule

// File: rtl/nnp_track.sv
module nnp_track #(
  parameter int ADDR_W  = 16,
  parameter int ENTRIES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] q_addr_i,
  output logic              hit_o,
  output logic              full_o,
  input  logic              alloc_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic              free_i,
  input  logic [ADDR_W-1:0] free_addr_i
);
  localparam int IdxW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q;
  logic [ADDR_W-1:0]  addr_q [ENTRIES];
  logic [ENTRIES-1:0] q_match;
  logic [ENTRIES-1:0] f_match;
  logic [IdxW-1:0]    slot;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign q_match[g] = vld_q[g] && (addr_q[g] == q_addr_i);
    assign f_match[g] = vld_q[g] && (addr_q[g] == free_addr_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g]  <= 1'b0;
        addr_q[g] <= '0;
      end else if (alloc_i && (slot == IdxW'(g))) begin
        vld_q[g]  <= 1'b1;
        addr_q[g] <= alloc_addr_i;
      end else if (free_i && f_match[g]) begin
        vld_q[g]  <= 1'b0;
      end
    end
  end

  // lowest free entry
  always_comb begin
    slot = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_q[i]) slot = IdxW'(i);
    end
  end

  assign hit_o  = |q_match;
  assign full_o = &vld_q;

  assert_single_copy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(q_match));
  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !full_o);
  assert_free_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_i && !alloc_i && (free_addr_i == q_addr_i) && hit_o) |=>
      ($countones(vld_q) == $countones($past(vld_q)) - 1));
endmodule

// File: rtl/nnp_burst.sv
module nnp_burst #(
  parameter int ADDR_W = 16,
  parameter int NW     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [NW-1:0]     n_i,
  input  logic              hit_i,
  input  logic              full_i,
  input  logic              rdy_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] cand_o,
  output logic              pf_valid_o
);
  import nnp_pkg::*;

  burst_st_e         st_q;
  logic [ADDR_W-1:0] base_q;
  logic [NW-1:0]     idx_q;
  logic [NW-1:0]     lim_q;
  logic              adv;

  assign busy_o     = (st_q == BST_RUN);
  assign cand_o     = base_q + ADDR_W'(idx_q);
  assign pf_valid_o = busy_o && !hit_i && !full_i;
  // merged and dropped candidates advance without a handshake
  assign adv        = busy_o && (hit_i || full_i || rdy_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= BST_IDLE;
      base_q <= '0;
      idx_q  <= '0;
      lim_q  <= '0;
    end else if (start_i && (n_i != '0)) begin
      st_q   <= BST_RUN;
      base_q <= base_i;
      idx_q  <= NW'(1);
      lim_q  <= n_i;
    end else if (adv) begin
      if (idx_q == lim_q) st_q  <= BST_IDLE;
      else                idx_q <= idx_q + NW'(1);
    end
  end

  assert_stall_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_valid_o && !rdy_i) |=> (pf_valid_o && $stable(cand_o)));
  assert_start_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
  assert_ascending_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && adv && (idx_q != lim_q)) |=> (cand_o == $past(cand_o) + ADDR_W'(1)));
endmodule

// File: rtl/nnp_count.sv
module nnp_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dem_inc_i,
  input  logic             tot_inc_i,
  output logic [CNT_W-1:0] dem_cnt_o,
  output logic [CNT_W-1:0] tot_cnt_o
);
  logic [CNT_W-1:0] dem_q, tot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dem_q <= '0;
      tot_q <= '0;
    end else begin
      if (dem_inc_i) dem_q <= dem_q + CNT_W'(1);
      if (tot_inc_i) tot_q <= tot_q + CNT_W'(1);
    end
  end

  assign dem_cnt_o = dem_q;
  assign tot_cnt_o = tot_q;

  assert_tot_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((tot_cnt_o == $past(tot_cnt_o)) || (tot_cnt_o == $past(tot_cnt_o) + CNT_W'(1))));
  assert_dem_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((dem_cnt_o == $past(dem_cnt_o)) || (dem_cnt_o == $past(dem_cnt_o) + CNT_W'(1))));
endmodule

// File: rtl/nextn_prefetcher.sv
module nextn_prefetcher #(
  parameter int ADDR_W    = 16,
  parameter int N_MAX     = 8,
  parameter int ENTRIES   = 8,
  parameter int CNT_W     = 16,
  parameter int DEPTH_RST = 2,
  localparam int NW       = $clog2(N_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [NW-1:0]     cfg_depth_i,
  input  logic              dem_valid_i,
  input  logic [ADDR_W-1:0] dem_addr_i,
  output logic              dem_ready_o,
  input  logic              cmp_valid_i,
  input  logic [ADDR_W-1:0] cmp_addr_i,
  output logic              pf_valid_o,
  output logic [ADDR_W-1:0] pf_addr_o,
  input  logic              pf_ready_i,
  output logic [CNT_W-1:0]  dem_cnt_o,
  output logic [CNT_W-1:0]  tot_cnt_o
);
  logic [NW-1:0]     depth;
  logic              busy, hit, full;
  logic [ADDR_W-1:0] cand, q_addr;
  logic              dem_acc, pf_fire, alloc, tot_inc;

  assign dem_ready_o = !busy;
  assign dem_acc     = dem_valid_i && !busy;
  // one lookup port: demands only when idle, candidates only when busy
  assign q_addr      = busy ? cand : dem_addr_i;
  assign pf_fire     = pf_valid_o && pf_ready_i;
  assign alloc       = (dem_acc && !hit && !full) || pf_fire;
  assign tot_inc     = (dem_acc && !hit) || pf_fire;
  assign pf_addr_o   = cand;

  nnp_depth_reg #(.N_MAX(N_MAX), .NW(NW), .DEPTH_RST(DEPTH_RST)) u_depth (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .val_i   (cfg_depth_i),
    .depth_o (depth)
  );

  nnp_track #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_track (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .q_addr_i     (q_addr),
    .hit_o        (hit),
    .full_o       (full),
    .alloc_i      (alloc),
    .alloc_addr_i (q_addr),
    .free_i       (cmp_valid_i),
    .free_addr_i  (cmp_addr_i)
  );

  nnp_burst #(.ADDR_W(ADDR_W), .NW(NW)) u_burst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (dem_acc),
    .base_i     (dem_addr_i),
    .n_i        (depth),
    .hit_i      (hit),
    .full_i     (full),
    .rdy_i      (pf_ready_i),
    .busy_o     (busy),
    .cand_o     (cand),
    .pf_valid_o (pf_valid_o)
  );

  nnp_count #(.CNT_W(CNT_W)) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dem_inc_i (dem_acc),
    .tot_inc_i (tot_inc),
    .dem_cnt_o (dem_cnt_o),
    .tot_cnt_o (tot_cnt_o)
  );

  assert_no_dup_issue_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_valid_o |-> (!hit && !dem_ready_o));
  assert_merge_no_alloc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc |-> !hit);
  assert_fire_counts_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_fire |=> (tot_cnt_o != $past(tot_cnt_o)));
endmodule

// File: tb/nextn_prefetcher_tb_top.sv
module nextn_prefetcher_tb_top;
  localparam int AW = 16;
  localparam int CW = 16;

  typedef struct packed {
    logic [15:0] addr;
    logic [15:0] first;
    logic [7:0]  cnt;
    logic [7:0]  totd;
    logic        flush;
  } vec_t;

  // depth 2, groups of three then a jump of five
  localparam vec_t VEC [6] = '{
    '{16'd0, 16'd1,  8'd2, 8'd3, 1'b0},
    '{16'd1, 16'd3,  8'd1, 8'd1, 1'b0},
    '{16'd2, 16'd4,  8'd1, 8'd1, 1'b1},
    '{16'd7, 16'd8,  8'd2, 8'd3, 1'b0},
    '{16'd8, 16'd10, 8'd1, 8'd1, 1'b0},
    '{16'd9, 16'd11, 8'd1, 8'd1, 1'b1}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [3:0]    cfg_depth_i = '0;
  logic          dem_valid_i = 1'b0;
  logic [AW-1:0] dem_addr_i = '0;
  logic          dem_ready_o;
  logic          cmp_valid_i = 1'b0;
  logic [AW-1:0] cmp_addr_i = '0;
  logic          pf_valid_o;
  logic [AW-1:0] pf_addr_o;
  logic          pf_ready_i = 1'b1;
  logic [CW-1:0] dem_cnt_o, tot_cnt_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  nextn_prefetcher dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_depth_i(cfg_depth_i),
    .dem_valid_i(dem_valid_i), .dem_addr_i(dem_addr_i), .dem_ready_o(dem_ready_o),
    .cmp_valid_i(cmp_valid_i), .cmp_addr_i(cmp_addr_i), .pf_valid_o(pf_valid_o),
    .pf_addr_o(pf_addr_o), .pf_ready_i(pf_ready_i), .dem_cnt_o(dem_cnt_o),
    .tot_cnt_o(tot_cnt_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic set_depth(input int v);
    @(negedge clk_i);
    cfg_we_i = 1'b1;
    cfg_depth_i = 4'(v);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic complete(input int a);
    @(negedge clk_i);
    cmp_valid_i = 1'b1;
    cmp_addr_i = AW'(a);
    @(negedge clk_i);
    cmp_valid_i = 1'b0;
  endtask

  // issue a demand; collect issued prefetches until the burst ends
  task automatic demand(input int a, input int n_lim, output int n_pf, output int first,
                        output int busy_cyc, output bit order_ok);
    int prev;
    n_pf = 0; first = -1; busy_cyc = 0; order_ok = 1; prev = a;
    @(negedge clk_i);
    dem_valid_i = 1'b1;
    dem_addr_i = AW'(a);
    @(negedge clk_i);
    dem_valid_i = 1'b0;
    while (!dem_ready_o) begin
      busy_cyc++;
      if (pf_valid_o && pf_ready_i) begin
        if (n_pf == 0) first = int'(pf_addr_o);
        if (int'(pf_addr_o) <= prev || int'(pf_addr_o) > a + n_lim) order_ok = 0;
        prev = int'(pf_addr_o);
        n_pf++;
      end
      @(negedge clk_i);
    end
  endtask

  initial begin
    while (!done) begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    int np, fp, bc, d0, t0;
    bit ok;

    // R1: reset state
    do_reset();
    check(pf_valid_o == 1'b0, "R1 pf_valid", int'(pf_valid_o), 0);
    check(dem_ready_o == 1'b1, "R1 dem_ready", int'(dem_ready_o), 1);
    check(dem_cnt_o == 0 && tot_cnt_o == 0, "R1 counters", int'(tot_cnt_o), 0);

    // R2 R3 R4 R10: vector walk, reset depth of 2
    foreach (VEC[i]) begin
      t0 = int'(tot_cnt_o);
      demand(int'(VEC[i].addr), 2, np, fp, bc, ok);
      check(np == int'(VEC[i].cnt), "R3 prefetch count", np, int'(VEC[i].cnt));
      if (np > 0) check(fp == int'(VEC[i].first), "R2 first prefetch", fp, int'(VEC[i].first));
      check(ok, "R2 ascending order", int'(ok), 1);
      check(bc == 2, "R2 burst length", bc, 2);
      check(int'(tot_cnt_o) - t0 == int'(VEC[i].totd), "R4 total delta",
            int'(tot_cnt_o) - t0, int'(VEC[i].totd));
      if (VEC[i].flush) begin
        for (int k = -2; k <= 2; k++) complete(int'(VEC[i].addr) + k);
      end
    end
    check(dem_cnt_o == 6, "R10 demand total", int'(dem_cnt_o), 6);
    check(tot_cnt_o == 10, "R10 request total", int'(tot_cnt_o), 10);
    check(int'(tot_cnt_o) * 3 == int'(dem_cnt_o) * 5, "R10 ratio 5/3",
          int'(tot_cnt_o) * 3, int'(dem_cnt_o) * 5);

    // R8: depth 0 gives no candidates, demand miss counts
    do_reset();
    set_depth(0);
    demand(50, 0, np, fp, bc, ok);
    check(np == 0 && bc == 0, "R8 depth zero", bc, 0);
    check(tot_cnt_o == 1, "R4 demand miss counted", int'(tot_cnt_o), 1);
    // R4: demand to outstanding block merges
    demand(50, 0, np, fp, bc, ok);
    check(dem_cnt_o == 2, "R4 merged demand counted", int'(dem_cnt_o), 2);
    check(tot_cnt_o == 1, "R4 merged demand no traffic", int'(tot_cnt_o), 1);
    // R7: completion frees entry
    complete(50);
    demand(50, 0, np, fp, bc, ok);
    check(tot_cnt_o == 2, "R7 freed block counts again", int'(tot_cnt_o), 2);

    // R8 clamp, R6 table full
    do_reset();
    set_depth(15);
    demand(100, 8, np, fp, bc, ok);
    check(bc == 8, "R8 clamp to N_MAX", bc, 8);
    check(np == 7 && fp == 101, "R6 fill then drop", np, 7);
    check(tot_cnt_o == 8, "R6 dropped not counted", int'(tot_cnt_o), 8);
    demand(200, 8, np, fp, bc, ok);
    check(np == 0, "R6 full drops all", np, 0);
    check(tot_cnt_o == 9, "R6 untracked demand counted", int'(tot_cnt_o), 9);
    demand(200, 8, np, fp, bc, ok);
    check(tot_cnt_o == 10, "R6 untracked demand not merged", int'(tot_cnt_o), 10);

    // R7 R3: free one entry, merged demand, freed candidate issued
    complete(103);
    set_depth(1);
    d0 = int'(dem_cnt_o);
    demand(102, 1, np, fp, bc, ok);
    check(np == 1 && fp == 103, "R7 freed candidate issued", fp, 103);
    check(tot_cnt_o == 11, "R3 merged demand plus one", int'(tot_cnt_o), 11);
    check(int'(dem_cnt_o) == d0 + 1, "R9 demand step", int'(dem_cnt_o), d0 + 1);

    // R5: backpressure holds request
    do_reset();
    pf_ready_i = 1'b0;
    @(negedge clk_i);
    dem_valid_i = 1'b1;
    dem_addr_i = 16'd10;
    @(negedge clk_i);
    dem_valid_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check(pf_valid_o == 1'b1 && pf_addr_o == 16'd11, "R5 stall hold", int'(pf_addr_o), 11);
      @(negedge clk_i);
    end
    check(tot_cnt_o == 1, "R5 no count while stalled", int'(tot_cnt_o), 1);
    pf_ready_i = 1'b1;
    @(negedge clk_i);
    check(pf_valid_o == 1'b1 && pf_addr_o == 16'd12, "R5 next after accept", int'(pf_addr_o), 12);
    @(negedge clk_i);
    check(dem_ready_o == 1'b1, "R2 burst ends", int'(dem_ready_o), 1);
    check(tot_cnt_o == 3, "R5 issued counted", int'(tot_cnt_o), 3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule